// File: doc/BRIEF.md
# Single-Cycle 32-bit Load/Store Processor Core

This core executes a small fixed-width instruction set of nine instructions: word load, word store, add, subtract, bitwise and, bitwise or, signed set-less-than, branch-if-equal and unconditional jump. Each instruction is fetched, decoded, executed and retired in one clock cycle. The core holds a program counter, a 32-entry register file, an ALU with a zero flag, an immediate sign extender, the next-PC logic (incrementer, branch-target adder and jump-target builder) and a two-level decoder. The decoder's first level works from the opcode and its second level from the function code.

The instruction memory and the data memory sit outside the core and are reached through separate ports. Both read combinationally: the instruction word arrives in the same cycle that the PC is presented, and the load data arrives in the same cycle that the address is presented. Data memory writes and register writes take effect on the rising clock edge. A synchronous active-low reset restarts execution at address 0. The reset does not clear the register contents.

Top module: `sc_core`

## Requirements
- R1: While rst_n is 0 at a rising edge, the PC becomes 0 on that edge, and imem_addr then shows 0. In any cycle in which rst_n is 0, dmem_we is 0 and no register is written.
- R2: After every instruction other than a taken branch or a jump, the next PC is PC+4. imem_addr always equals the PC.
- R3: An instruction with opcode bits[31:26] = 0x00 reads rs (bits 25..21) and rt (bits 20..16), and writes rd (bits 15..11). The value written is rs+rt for funct bits[5:0] = 0x20, rs-rt for 0x22, rs AND rt for 0x24, and rs OR rt for 0x25. The ALU result is presented on dmem_addr.
- R4: Funct 0x2A (signed set-less-than) writes 1 to rd when rs < rt as signed 32-bit values, and 0 otherwise.
- R5: Opcode 0x23 (load word) drives dmem_addr = rs + sign-extended bits[15:0], which may be negative, and writes dmem_rdata to rt.
- R6: Opcode 0x2B (store word) drives dmem_addr = rs + sign-extended bits[15:0], dmem_wdata = rt and dmem_we = 1. Memory is written on the rising edge.
- R7: Opcode 0x04 (branch if equal) subtracts rt from rs in the ALU. When the result is zero, the next PC is PC+4 + (sign-extended bits[15:0] << 2), for forward or backward offsets. Otherwise the next PC is PC+4.
- R8: Opcode 0x02 (jump) sets the next PC to {PC+4 bits[31:28], bits[25:0], 2'b00}.
- R9: Register 0 always reads as 0. A write that names register 0 is discarded.
- R10: dmem_we is 1 only during a store word instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state updates on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| imem_addr | output | 32 | Instruction fetch address (the PC) |
| imem_rdata | input | 32 | Instruction word at imem_addr, same cycle |
| dmem_addr | output | 32 | Data address (ALU result) |
| dmem_wdata | output | 32 | Store data (register rt) |
| dmem_we | output | 1 | Data memory write enable |
| dmem_rdata | input | 32 | Load data at dmem_addr, same cycle |

## Verification
Several behaviours are checked by assertions on every cycle:
- the PC follows PC+4 for straight-line instructions;
- a taken or a not-taken compare selects the branch target or PC+4;
- a jump places its address field in the low PC bits;
- the data write enable is only ever raised by a store, and it then carries the rt value;
- every enabled register write lands in the named register.

Other behaviours only show in the bench's scenarios, which run a reference model in step with the core:
- the arithmetic results, including signed set-less-than with a negative operand;
- a load with a negative offset;
- the discarding of writes to register 0, which shows through a later store;
- the skipping of instructions by branches and jumps;
- the restart after a reset asserted in mid-program.

// File: rtl/sc_pkg.sv
// Package sc_pkg: shared widths, opcode and funct codes, ALU operation
// type and the decoded control bundle for the single-cycle core.
package sc_pkg;
    localparam int XLEN     = 32;
    localparam int NREGS    = 32;
    localparam int RADDR_W  = $clog2(NREGS);

    localparam logic [5:0] OPC_ALU   = 6'h00;
    localparam logic [5:0] OPC_JUMP  = 6'h02;
    localparam logic [5:0] OPC_BEQ   = 6'h04;
    localparam logic [5:0] OPC_LOAD  = 6'h23;
    localparam logic [5:0] OPC_STORE = 6'h2B;

    localparam logic [5:0] FN_ADD = 6'h20;
    localparam logic [5:0] FN_SUB = 6'h22;
    localparam logic [5:0] FN_AND = 6'h24;
    localparam logic [5:0] FN_OR  = 6'h25;
    localparam logic [5:0] FN_SLT = 6'h2A;

    typedef enum logic [2:0] {
        ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_SLT
    } alu_op_e;

    // class of ALU use chosen by the opcode level of the decoder
    typedef enum logic [1:0] {
        CLS_ADD, CLS_SUB, CLS_FUNCT
    } alu_cls_e;

    typedef struct packed {
        logic    reg_write;   // write the register file
        logic    dst_rd;      // destination is rd (else rt)
        logic    use_imm;     // ALU operand b is the immediate
        logic    mem_write;   // store to data memory
        logic    load_wb;     // write back memory data (else ALU result)
        logic    branch;      // conditional branch on zero
        logic    jump;        // unconditional jump
        alu_op_e alu_op;
    } ctrl_t;
endpackage

// File: rtl/sc_decode.sv
// Module sc_decode: two-level instruction decoder. The first level maps
// the opcode to datapath controls and an ALU class. The second level maps
// the funct code to an ALU operation for register-register instructions.
// Assumes: unknown opcodes and unknown funct codes retire as no-ops (no
// register or memory write, next PC is PC+4).
module sc_decode
    import sc_pkg::*;
(
    input  logic [5:0] opcode,
    input  logic [5:0] funct,
    output ctrl_t      ctrl
);
    alu_cls_e cls;
    logic     main_rw;
    logic     fn_ok;
    alu_op_e  fn_op;

    // opcode level: datapath steering and ALU class
    always_comb begin
        ctrl    = '0;
        ctrl.alu_op = ALU_ADD;
        main_rw = 1'b0;
        cls     = CLS_ADD;
        case (opcode)
            OPC_ALU: begin
                main_rw     = 1'b1;
                ctrl.dst_rd = 1'b1;
                cls         = CLS_FUNCT;
            end
            OPC_LOAD: begin
                main_rw      = 1'b1;
                ctrl.use_imm = 1'b1;
                ctrl.load_wb = 1'b1;
            end
            OPC_STORE: begin
                ctrl.use_imm   = 1'b1;
                ctrl.mem_write = 1'b1;
            end
            OPC_BEQ: begin
                ctrl.branch = 1'b1;
                cls         = CLS_SUB;
            end
            OPC_JUMP: ctrl.jump = 1'b1;
            default: ;
        endcase
        case (cls)
            CLS_SUB:   ctrl.alu_op = ALU_SUB;
            CLS_FUNCT: ctrl.alu_op = fn_op;
            default:   ctrl.alu_op = ALU_ADD;
        endcase
        ctrl.reg_write = main_rw && ((cls != CLS_FUNCT) || fn_ok);
    end

    // funct level: ALU operation for register-register instructions
    always_comb begin
        fn_ok = 1'b1;
        case (funct)
            FN_ADD:  fn_op = ALU_ADD;
            FN_SUB:  fn_op = ALU_SUB;
            FN_AND:  fn_op = ALU_AND;
            FN_OR:   fn_op = ALU_OR;
            FN_SLT:  fn_op = ALU_SLT;
            default: begin
                fn_op = ALU_ADD;
                fn_ok = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/sc_regfile.sv
// Module sc_regfile: register file with two combinational read ports and
// one write port written on the rising edge. Entry 0 reads as zero and
// never stores. Assumes: contents are not reset; software initialises them.
module sc_regfile #(
    parameter int W     = 32,
    parameter int DEPTH = 32,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] wa,
    input  logic [W-1:0]  wd,
    input  logic [AW-1:0] ra1,
    input  logic [AW-1:0] ra2,
    output logic [W-1:0]  rd1,
    output logic [W-1:0]  rd2
);
    logic [W-1:0] mem [DEPTH];

    // write port: store on the edge, never into entry 0
    always_ff @(posedge clk) begin
        if (we && (wa != '0)) mem[wa] <= wd;
    end

    // read ports: entry 0 is hard zero
    always_comb begin
        rd1 = (ra1 == '0) ? '0 : mem[ra1];
        rd2 = (ra2 == '0) ? '0 : mem[ra2];
    end

    // R3: an enabled write to a nonzero entry is visible on the next cycle
    p_write_lands_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (we && (wa != '0)) |=> (mem[$past(wa)] == $past(wd)));
endmodule

// File: rtl/sc_alu.sv
// Module sc_alu: combinational ALU with add, subtract, and, or and signed
// set-less-than, plus a zero flag on the result. Assumes: no overflow trap.
module sc_alu
    import sc_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  alu_op_e      op,
    output logic [W-1:0] y,
    output logic         zero
);
    // operation select
    always_comb begin
        case (op)
            ALU_SUB: y = a - b;
            ALU_AND: y = a & b;
            ALU_OR:  y = a | b;
            ALU_SLT: y = {{(W-1){1'b0}}, ($signed(a) < $signed(b))};
            default: y = a + b;
        endcase
    end

    // zero flag used by the branch compare
    always_comb zero = (y == '0);
endmodule

// File: rtl/sc_nextpc.sv
// Module sc_nextpc: next-PC selection from PC+4, the branch target
// (PC+4 plus the word-scaled immediate) and the jump target (PC+4 upper
// nibble with the 26-bit field). Assumes: 32-bit addresses.
module sc_nextpc
    import sc_pkg::*;
(
    input  logic [XLEN-1:0] pc,
    input  logic [XLEN-1:0] imm_ext,
    input  logic [25:0]     jfield,
    input  logic            take_branch,
    input  logic            jump,
    output logic [XLEN-1:0] next_pc
);
    logic [XLEN-1:0] pc_inc;
    logic [XLEN-1:0] br_tgt;
    logic [XLEN-1:0] j_tgt;

    // candidate targets
    always_comb begin
        pc_inc = pc + 32'd4;
        br_tgt = pc_inc + {imm_ext[XLEN-3:0], 2'b00};
        j_tgt  = {pc_inc[XLEN-1:XLEN-4], jfield, 2'b00};
    end

    // target select: jump over branch over sequential
    always_comb begin
        if (jump)             next_pc = j_tgt;
        else if (take_branch) next_pc = br_tgt;
        else                  next_pc = pc_inc;
    end
endmodule

// File: rtl/sc_core.sv
// Module sc_core: single-cycle processor top. Holds the PC, splits the
// instruction fields, sign-extends the immediate and wires the decoder,
// register file, ALU and next-PC logic. Assumes: both memories answer
// combinationally, and writes are suppressed while reset is asserted.
module sc_core
    import sc_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    output logic [XLEN-1:0] imem_addr,
    input  logic [XLEN-1:0] imem_rdata,
    output logic [XLEN-1:0] dmem_addr,
    output logic [XLEN-1:0] dmem_wdata,
    output logic            dmem_we,
    input  logic [XLEN-1:0] dmem_rdata
);
    logic [XLEN-1:0]    pc;
    logic [XLEN-1:0]    next_pc;
    logic [5:0]         f_op;
    logic [5:0]         f_fn;
    logic [RADDR_W-1:0] f_rs, f_rt, f_rd;
    logic [15:0]        f_imm;
    logic [XLEN-1:0]    imm_ext;
    ctrl_t              ctrl;
    logic [XLEN-1:0]    rs_val, rt_val;
    logic [XLEN-1:0]    alu_b, alu_y;
    logic               alu_zero;
    logic               rf_we;
    logic [RADDR_W-1:0] rf_wa;
    logic [XLEN-1:0]    rf_wd;

    // field split and sign extension
    always_comb begin
        f_op    = imem_rdata[31:26];
        f_rs    = imem_rdata[25:21];
        f_rt    = imem_rdata[20:16];
        f_rd    = imem_rdata[15:11];
        f_fn    = imem_rdata[5:0];
        f_imm   = imem_rdata[15:0];
        imm_ext = {{(XLEN-16){f_imm[15]}}, f_imm};
    end

    sc_decode u_dec (
        .opcode (f_op),
        .funct  (f_fn),
        .ctrl   (ctrl)
    );

    sc_regfile #(.W(XLEN), .DEPTH(NREGS)) u_rf (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (rf_we),
        .wa    (rf_wa),
        .wd    (rf_wd),
        .ra1   (f_rs),
        .ra2   (f_rt),
        .rd1   (rs_val),
        .rd2   (rt_val)
    );

    // ALU operand b select
    always_comb alu_b = ctrl.use_imm ? imm_ext : rt_val;

    sc_alu #(.W(XLEN)) u_alu (
        .a    (rs_val),
        .b    (alu_b),
        .op   (ctrl.alu_op),
        .y    (alu_y),
        .zero (alu_zero)
    );

    sc_nextpc u_npc (
        .pc          (pc),
        .imm_ext     (imm_ext),
        .jfield      (imem_rdata[25:0]),
        .take_branch (ctrl.branch && alu_zero),
        .jump        (ctrl.jump),
        .next_pc     (next_pc)
    );

    // write-back steering, gated by reset
    always_comb begin
        rf_we = ctrl.reg_write && rst_n;
        rf_wa = ctrl.dst_rd ? f_rd : f_rt;
        rf_wd = ctrl.load_wb ? dmem_rdata : alu_y;
    end

    // memory port drive
    always_comb begin
        imem_addr  = pc;
        dmem_addr  = alu_y;
        dmem_wdata = rt_val;
        dmem_we    = ctrl.mem_write && rst_n;
    end

    // program counter with synchronous active-low reset
    always_ff @(posedge clk) begin
        if (!rst_n) pc <= '0;
        else        pc <= next_pc;
    end

    // R2: straight-line instructions advance by one word
    p_seq_pc_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl.branch && !ctrl.jump) |=> (pc == $past(pc) + 32'd4));

    // R7: taken compare goes to PC+4 plus scaled displacement
    p_beq_taken_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl.branch && (rs_val == rt_val)) |=>
        (pc == $past(pc) + 32'd4 + {$past(imm_ext[XLEN-3:0]), 2'b00}));

    // R7: untaken compare falls through
    p_beq_fall_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl.branch && (rs_val != rt_val)) |=> (pc == $past(pc) + 32'd4));

    // R8: a jump places its address field in the low PC bits
    p_jump_field_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl.jump |=> (pc[27:0] == {$past(imem_rdata[25:0]), 2'b00}));

    // R10, R6: write enable only for stores, carrying rt
    p_store_only_r10: assert property (@(posedge clk) disable iff (!rst_n)
        dmem_we |-> ((imem_rdata[31:26] == OPC_STORE) && (dmem_wdata == rt_val)));
endmodule

// File: tb/sim_sc_core.sv
module sim_sc_core;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] imem_addr, imem_rdata, dmem_addr, dmem_wdata, dmem_rdata;
    logic        dmem_we;

    logic [31:0] imem [64];
    logic [31:0] dmem [64];
    logic [31:0] ref_dm [64];
    logic [31:0] ref_rf [32];
    logic [31:0] ref_pc;
    string       pc_tag;
    int          n_cmp = 0;
    int          n_bad = 0;

    always #4 clk = ~clk;

    sc_core u0 (
        .clk(clk), .rst_n(rst_n),
        .imem_addr(imem_addr), .imem_rdata(imem_rdata),
        .dmem_addr(dmem_addr), .dmem_wdata(dmem_wdata),
        .dmem_we(dmem_we), .dmem_rdata(dmem_rdata)
    );

    assign imem_rdata = imem[imem_addr[7:2]];
    assign dmem_rdata = dmem[dmem_addr[7:2]];
    always @(posedge clk) if (dmem_we) dmem[dmem_addr[7:2]] <= dmem_wdata;

    function automatic logic [31:0] enc_r(int rs, int rt, int rd, logic [5:0] fn);
        return {6'h00, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
    endfunction
    function automatic logic [31:0] enc_i(logic [5:0] op, int rs, int rt, int imm);
        return {op, 5'(rs), 5'(rt), 16'(imm)};
    endfunction
    function automatic logic [31:0] enc_j(int tgt);
        return {6'h02, 26'(tgt)};
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // one reference instruction: compare ports, then advance the model
    task automatic step();
        logic [31:0] ins, a, b, ext, res, pc4;
        logic [5:0]  op, fn;
        int          rs, rt, rd;
        string       tg;
        ins = imem[ref_pc[7:2]];
        op = ins[31:26]; fn = ins[5:0];
        rs = int'(ins[25:21]); rt = int'(ins[20:16]); rd = int'(ins[15:11]);
        ext = {{16{ins[15]}}, ins[15:0]};
        a = ref_rf[rs]; b = ref_rf[rt];
        pc4 = ref_pc + 4;
        chk(pc_tag, imem_addr, ref_pc);
        chk("R10", {31'd0, dmem_we}, {31'd0, op == 6'h2B});
        pc_tag = "R2";
        case (op)
            6'h00: begin
                tg = "R3";
                case (fn)
                    6'h20: res = a + b;
                    6'h22: res = a - b;
                    6'h24: res = a & b;
                    6'h25: res = a | b;
                    default: begin
                        res = ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
                        tg = "R4";
                    end
                endcase
                chk(tg, dmem_addr, res);
                if (rd != 0) ref_rf[rd] = res;
                ref_pc = pc4;
            end
            6'h23: begin
                res = a + ext;
                chk("R5", dmem_addr, res);
                ref_rf[rt] = ref_dm[res[7:2]];
                ref_pc = pc4;
            end
            6'h2B: begin
                res = a + ext;
                chk("R6", dmem_addr, res);
                chk((rt == 0) ? "R9" : "R6", dmem_wdata, b);
                ref_dm[res[7:2]] = b;
                ref_pc = pc4;
            end
            6'h04: begin
                ref_pc = (a == b) ? pc4 + {ext[29:0], 2'b00} : pc4;
                pc_tag = "R7";
            end
            default: begin
                ref_pc = {pc4[31:28], ins[25:0], 2'b00};
                pc_tag = "R8";
            end
        endcase
    endtask

    initial begin
        for (int i = 0; i < 64; i++) begin
            imem[i] = enc_i(6'h04, 0, 0, -1);
            dmem[i] = 32'd0;
        end
        for (int i = 0; i < 32; i++) ref_rf[i] = 32'd0;
        dmem[0] = 32'd7;
        dmem[1] = 32'hFFFF_FFFD;
        imem[0]  = enc_i(6'h23, 0, 1, 0);
        imem[1]  = enc_i(6'h23, 0, 2, 4);
        imem[2]  = enc_r(1, 2, 3, 6'h20);
        imem[3]  = enc_r(1, 2, 4, 6'h22);
        imem[4]  = enc_r(1, 2, 5, 6'h24);
        imem[5]  = enc_r(1, 2, 6, 6'h25);
        imem[6]  = enc_r(2, 1, 7, 6'h2A);
        imem[7]  = enc_r(1, 2, 8, 6'h2A);
        imem[8]  = enc_r(1, 1, 0, 6'h20);
        imem[9]  = enc_i(6'h2B, 0, 0, 8);
        imem[10] = enc_i(6'h2B, 0, 3, 12);
        imem[11] = enc_i(6'h2B, 0, 4, 16);
        imem[12] = enc_i(6'h2B, 0, 5, 20);
        imem[13] = enc_i(6'h2B, 0, 6, 24);
        imem[14] = enc_i(6'h2B, 0, 7, 28);
        imem[15] = enc_i(6'h2B, 0, 8, 32);
        imem[16] = enc_i(6'h04, 1, 2, 3);
        imem[17] = enc_i(6'h04, 3, 3, 1);
        imem[18] = enc_i(6'h2B, 0, 1, 36);
        imem[19] = enc_i(6'h23, 3, 9, -4);
        imem[20] = enc_i(6'h2B, 0, 9, 40);
        imem[21] = enc_j(23);
        imem[22] = enc_i(6'h2B, 0, 1, 44);
        imem[23] = enc_r(6, 0, 10, 6'h2A);
        imem[24] = enc_i(6'h2B, 0, 10, 44);
        for (int i = 0; i < 64; i++) ref_dm[i] = dmem[i];

        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1", imem_addr, 32'd0);
        chk("R1", {31'd0, dmem_we}, 32'd0);
        ref_pc = 32'd0;
        pc_tag = "R1";
        rst_n = 1'b1;
        for (int c = 0; c < 40; c++) begin
            #1 step();
            @(negedge clk);
        end
        rst_n = 1'b0;
        #1 chk("R1", {31'd0, dmem_we}, 32'd0);
        @(negedge clk);
        chk("R1", imem_addr, 32'd0);
        ref_pc = 32'd0;
        pc_tag = "R1";
        rst_n = 1'b1;
        for (int c = 0; c < 40; c++) begin
            #1 step();
            @(negedge clk);
        end
        for (int i = 0; i < 16; i++) chk("R6", dmem[i], ref_dm[i]);
        chk("R9", dmem[2], 32'd0);
        chk("R4", dmem[11], 32'd1);
        chk("R5", dmem[10], 32'd7);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL R2 watchdog actual=%h expected=%h", 32'd1, 32'd0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule